// File: doc/BRIEF.md
# Two-Stage Successive-Approximation and Ramp Conversion Controller

This controller sequences one conversion of a 14-bit converter that resolves the input in two stages. A start strobe opens a sampling window of fixed length. After that window the controller runs a coarse search. This search finds 10 bits by successive approximation, most significant bit first. It drives one switch control per capacitor-array bit and consumes one comparator decision per bit.

The fine stage follows. The controller issues single-cycle ramp step pulses on the held node, in a direction taken from the last coarse decision. After every step it waits for a comparator decision. It stops at the first decision that differs from the last coarse decision, or after 15 steps. It then folds the step count into the coarse code and presents a 14-bit word with a one-cycle done pulse.

The comparator interface is a valid-qualified stream with no ready signal, so the block never applies back-pressure. A decision is consumed on any cycle in which `cmp_valid_i` is high while the controller is waiting for one. A valid strobe that arrives at any other time is dropped. The result word is a plain registered output, qualified by `done_o`. It has no hold-off, and a consumer must capture it on the done pulse or before the next conversion ends. Comparison latency may vary from one decision to the next.

Top module: `sar_ramp_ctrl`

## Requirements
- R1: While reset is held and just after it is released, `sample_en_o`, `ramp_step_o`, `done_o`, `cap_sw_o` and `result_o` are all zero.
- R2: A start strobe seen while idle raises `sample_en_o` from the next cycle for exactly SAMPLE_CYCLES cycles (default 4). During sampling, `cap_sw_o` is all zero and no ramp step is issued.
- R3: The cycle after sampling ends, `cap_sw_o` equals 10'h200, with only the MSB trial bit set. Each consumed coarse decision writes its value (1 keeps, 0 clears) into the current trial bit and sets the next lower bit.
- R4: The coarse stage consumes exactly 10 decisions, one per `cmp_valid_i` strobe, and only a strobe can advance it.
- R5: During the fine stage, `ramp_dir_o` equals the 10th coarse decision, where 1 means charge and 0 means discharge. It stays constant until the conversion ends.
- R6: The fine stage issues a one-cycle `ramp_step_o` pulse and then issues no further step until a comparator decision has been consumed.
- R7: The fine stage ends on the first consumed decision that differs from the 10th coarse decision. The fine count equals the number of steps issued.
- R8: If the decision has not flipped after 15 steps, the fine stage ends anyway with a count of 15.
- R9: Let C be the coarse code and n the fine count. The result is C*16+n when charging and C*16-n when discharging, clamped to the range 0..16383.
- R10: `done_o` is a one-cycle pulse that occurs in the cycle `result_o` takes its new value. `result_o` holds at all other times.
- R11: A start strobe received while a conversion is in progress is ignored and does not cause a new sampling phase.
- R12: A `cmp_valid_i` strobe that arrives while no decision is awaited, for example during sampling, has no effect on the conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start-of-conversion strobe, honoured only when idle |
| cmp_valid_i | input | 1 | Comparator decision valid strobe |
| cmp_dec_i | input | 1 | Comparator decision, 1 = held input above trial level |
| sample_en_o | output | 1 | Sample switch enable |
| cap_sw_o | output | 10 | Capacitor-array trial/switch controls, bit 9 is MSB |
| ramp_step_o | output | 1 | One-cycle ramp step pulse |
| ramp_dir_o | output | 1 | Ramp direction, 1 = charge, 0 = discharge |
| result_o | output | 14 | Converted word |
| done_o | output | 1 | One-cycle pulse when result_o updates |

## Verification
The assertions assume that `cmp_valid_i` is a single-cycle strobe raised only after the relevant trial setting or ramp step is visible. They also assume that start is a short pulse. The stimulus raises each decision strobe on a falling edge, one or more cycles after it has seen the matching `cap_sw_o` value or step pulse, and drops it at the next falling edge. Stray valid and start strobes are injected only at moments when the requirements say they must be dropped.

// File: rtl/sar_ramp_pkg.sv
package sar_ramp_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SAMPLE,
    ST_COARSE,
    ST_STEP,
    ST_WAIT
  } ctrl_state_t;
endpackage

// File: rtl/sar_trial_reg.sv
module sar_trial_reg #(
  parameter int NBITS = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             load_i,
  input  logic             decide_i,
  input  logic             dec_i,
  output logic [NBITS-1:0] trial_o,
  output logic             at_lsb_o
);
  localparam int IW = (NBITS > 1) ? $clog2(NBITS) : 1;

  logic [NBITS-1:0] q, q_nxt;
  logic [IW-1:0]    idx, idx_nxt;

  always_comb begin
    q_nxt   = q;
    idx_nxt = idx;
    if (clr_i) begin
      q_nxt   = '0;
      idx_nxt = '0;
    end else if (load_i) begin
      q_nxt          = '0;
      q_nxt[NBITS-1] = 1'b1;
      idx_nxt        = IW'(NBITS - 1);
    end else if (decide_i) begin
      q_nxt[idx] = dec_i;
      if (idx != '0) begin
        q_nxt[idx - IW'(1)] = 1'b1;
        idx_nxt             = idx - IW'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q   <= '0;
      idx <= '0;
    end else begin
      q   <= q_nxt;
      idx <= idx_nxt;
    end
  end

  assign trial_o  = q;
  assign at_lsb_o = (idx == '0);

  // R3: a load leaves only the MSB trial bit set
  a_r3_msb_first: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && !clr_i) |=> (trial_o == {1'b1, {(NBITS-1){1'b0}}}));
endmodule

// File: rtl/ramp_step_counter.sv
module ramp_step_counter #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          inc_i,
  output logic [CW-1:0] cnt_o,
  output logic          sat_o
);
  localparam logic [CW-1:0] CMAX = {CW{1'b1}};

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)                      cnt <= '0;
    else if (clr_i)                  cnt <= '0;
    else if (inc_i && cnt != CMAX)   cnt <= cnt + CW'(1);
  end

  assign cnt_o = cnt;
  assign sat_o = (cnt == CMAX);

  // R8: the count stays at its maximum once it gets there
  a_r8_hold_at_max: assert property (@(posedge clk) disable iff (!rst_n)
    (sat_o && !clr_i) |=> sat_o);
endmodule

// File: rtl/code_merge.sv
module code_merge #(
  parameter int CB = 10,
  parameter int FB = 4
) (
  input  logic [CB-1:0]    coarse_i,
  input  logic [FB-1:0]    fine_i,
  input  logic             charge_i,
  output logic [CB+FB-1:0] word_o
);
  localparam int OW = CB + FB;
  localparam logic [OW:0] WMAX = {1'b0, {OW{1'b1}}};

  logic [OW:0] base, fext, sum, diff;

  always_comb begin
    base = {1'b0, coarse_i, {FB{1'b0}}};
    fext = {{(OW+1-FB){1'b0}}, fine_i};
    sum  = base + fext;
    diff = base - fext;
    if (charge_i) begin
      word_o = (sum > WMAX) ? {OW{1'b1}} : sum[OW-1:0];
    end else begin
      word_o = (base < fext) ? '0 : diff[OW-1:0];
    end
  end
endmodule

// File: rtl/sar_ramp_ctrl.sv
module sar_ramp_ctrl
  import sar_ramp_pkg::*;
#(
  parameter int COARSE_BITS   = 10,
  parameter int FINE_BITS     = 4,
  parameter int SAMPLE_CYCLES = 4
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           start_i,
  input  logic                           cmp_valid_i,
  input  logic                           cmp_dec_i,
  output logic                           sample_en_o,
  output logic [COARSE_BITS-1:0]         cap_sw_o,
  output logic                           ramp_step_o,
  output logic                           ramp_dir_o,
  output logic [COARSE_BITS+FINE_BITS-1:0] result_o,
  output logic                           done_o
);
  localparam int RW = COARSE_BITS + FINE_BITS;
  localparam int SW = (SAMPLE_CYCLES > 1) ? $clog2(SAMPLE_CYCLES) : 1;
  localparam logic [SW-1:0] SLAST = SW'(SAMPLE_CYCLES - 1);

  ctrl_state_t state;
  logic [SW-1:0]          scnt;
  logic                   last_dec;
  logic [RW-1:0]          result_q;
  logic                   done_q;

  logic                   accept, load_msb, decide, at_lsb, finish;
  logic [COARSE_BITS-1:0] trial;
  logic [FINE_BITS-1:0]   fcnt;
  logic                   fsat;
  logic [RW-1:0]          merged;

  assign accept   = (state == ST_IDLE) && start_i;
  assign load_msb = (state == ST_SAMPLE) && (scnt == SLAST);
  assign decide   = (state == ST_COARSE) && cmp_valid_i;
  assign finish   = (state == ST_WAIT) && cmp_valid_i &&
                    ((cmp_dec_i != last_dec) || fsat);

  sar_trial_reg #(.NBITS(COARSE_BITS)) u_trial (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_i    (accept),
    .load_i   (load_msb),
    .decide_i (decide),
    .dec_i    (cmp_dec_i),
    .trial_o  (trial),
    .at_lsb_o (at_lsb)
  );

  ramp_step_counter #(.CW(FINE_BITS)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr_i (load_msb),
    .inc_i (state == ST_STEP),
    .cnt_o (fcnt),
    .sat_o (fsat)
  );

  code_merge #(.CB(COARSE_BITS), .FB(FINE_BITS)) u_merge (
    .coarse_i (trial),
    .fine_i   (fcnt),
    .charge_i (last_dec),
    .word_o   (merged)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      scnt     <= '0;
      last_dec <= 1'b0;
      result_q <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start_i) begin
            state <= ST_SAMPLE;
            scnt  <= '0;
          end
        end
        ST_SAMPLE: begin
          if (scnt == SLAST) state <= ST_COARSE;
          else               scnt  <= scnt + SW'(1);
        end
        ST_COARSE: begin
          if (cmp_valid_i && at_lsb) begin
            last_dec <= cmp_dec_i;
            state    <= ST_STEP;
          end
        end
        ST_STEP: state <= ST_WAIT;
        ST_WAIT: begin
          if (finish) begin
            result_q <= merged;
            done_q   <= 1'b1;
            state    <= ST_IDLE;
          end else if (cmp_valid_i) begin
            state <= ST_STEP;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign sample_en_o = (state == ST_SAMPLE);
  assign cap_sw_o    = trial;
  assign ramp_step_o = (state == ST_STEP);
  assign ramp_dir_o  = last_dec;
  assign result_o    = result_q;
  assign done_o      = done_q;

  // R10: done lasts a single cycle
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  // R10: the result word changes only together with done
  a_r10_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable(result_o));
  // R6: step pulses never come back to back
  a_r6_step_gap: assert property (@(posedge clk) disable iff (!rst_n)
    ramp_step_o |=> !ramp_step_o);
  // R2: sampling is quiet on the array and the ramp
  a_r2_sample_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    sample_en_o |-> (!ramp_step_o && cap_sw_o == '0));
  // R5: direction holds while waiting for a fine decision
  a_r5_dir_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAIT) |-> $stable(ramp_dir_o));
endmodule

// File: tb/sim_sar_ramp_ctrl.sv
module sim_sar_ramp_ctrl;
  localparam int SAMP = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic        cmp_valid_i = 1'b0;
  logic        cmp_dec_i = 1'b0;
  logic        sample_en_o;
  logic [9:0]  cap_sw_o;
  logic        ramp_step_o;
  logic        ramp_dir_o;
  logic [13:0] result_o;
  logic        done_o;

  int checks = 0;
  int fails  = 0;
  int exp_q[$];
  int last_exp = 0;
  logic prev_done = 1'b0;

  always #4 clk = ~clk;

  sar_ramp_ctrl #(.COARSE_BITS(10), .FINE_BITS(4), .SAMPLE_CYCLES(SAMP)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .cmp_valid_i(cmp_valid_i),
    .cmp_dec_i(cmp_dec_i), .sample_en_o(sample_en_o), .cap_sw_o(cap_sw_o),
    .ramp_step_o(ramp_step_o), .ramp_dir_o(ramp_dir_o), .result_o(result_o),
    .done_o(done_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  // monitor: pop expected words as done pulses appear
  always @(negedge clk) begin
    if (rst_n) begin
      if (done_o) begin
        if (prev_done) check(1'b0, "R10 done width", 2, 1);
        if (exp_q.size() == 0) begin
          check(1'b0, "R10 unexpected done", 1, 0);
        end else begin
          last_exp = exp_q.pop_front();
          check(result_o == 14'(last_exp), "R9 result word", int'(result_o), last_exp);
        end
      end
      prev_done = done_o;
    end
  end

  task automatic run_conv(input logic [9:0] d, input int k, input int lat, input bit stray_start);
    int n, steps, t, cnt, base, expv;
    logic [9:0] trial;
    bit flip;
    cnt  = (k <= 15) ? k : 15;
    base = int'(d) * 16;
    if (d[0]) expv = (base + cnt > 16383) ? 16383 : base + cnt;
    else      expv = (base < cnt) ? 0 : base - cnt;
    exp_q.push_back(expv);

    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    n = 0;
    while (sample_en_o && n < 50) begin
      n++;
      // R12: stray decision strobe during sampling
      if (n == 2) begin cmp_valid_i = 1'b1; cmp_dec_i = ~d[9]; end
      if (n == 3) cmp_valid_i = 1'b0;
      // R11: stray start during sampling
      if (stray_start) start_i = (n == 2);
      @(negedge clk);
    end
    start_i = 1'b0;
    cmp_valid_i = 1'b0;
    check(n == SAMP, "R2 sample length", n, SAMP);

    trial = 10'h200;
    for (int i = 9; i >= 0; i--) begin
      for (int w = 1; w < lat; w++) @(negedge clk);
      check(cap_sw_o == trial, "R3 trial setting", int'(cap_sw_o), int'(trial));
      cmp_valid_i = 1'b1;
      cmp_dec_i   = d[i];
      if (stray_start && i == 5) start_i = 1'b1;
      @(negedge clk);
      cmp_valid_i = 1'b0;
      start_i     = 1'b0;
      trial[i] = d[i];
      if (i > 0) trial[i-1] = 1'b1;
    end
    check(cap_sw_o == d, "R4 coarse code after 10 decisions", int'(cap_sw_o), int'(d));

    steps = 0;
    forever begin
      t = 0;
      while (!ramp_step_o && t < 20) begin @(negedge clk); t++; end
      steps++;
      if (steps == 1)
        check(ramp_dir_o == d[0], "R5 ramp direction", int'(ramp_dir_o), int'(d[0]));
      @(negedge clk);
      for (int w = 1; w < lat; w++) begin
        check(!ramp_step_o, "R6 no step while waiting", int'(ramp_step_o), 0);
        @(negedge clk);
      end
      flip = (steps >= k);
      cmp_valid_i = 1'b1;
      cmp_dec_i   = flip ? ~d[0] : d[0];
      @(negedge clk);
      cmp_valid_i = 1'b0;
      if (flip || steps >= 15 || steps > 30) break;
    end
    if (k <= 15) check(steps == k, "R7 steps until flip", steps, k);
    else         check(steps == 15, "R8 saturated step count", steps, 15);

    for (int w = 0; w < 4; w++) begin
      @(negedge clk);
      if (stray_start)
        check(!sample_en_o, "R11 no sampling from stray start", int'(sample_en_o), 0);
      check(!ramp_step_o, "R7 no step after end", int'(ramp_step_o), 0);
    end
    check(result_o == 14'(expv), "R10 result holds", int'(result_o), expv);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(sample_en_o == 0 && ramp_step_o == 0 && done_o == 0, "R1 controls in reset",
          int'({sample_en_o, ramp_step_o, done_o}), 0);
    check(cap_sw_o == 0 && result_o == 0, "R1 words in reset", int'(result_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(sample_en_o == 0 && cap_sw_o == 0 && result_o == 0, "R1 after release",
          int'(cap_sw_o), 0);

    run_conv(10'b1010101011, 3, 1, 1'b0);   // charge
    run_conv(10'b0110011000, 5, 2, 1'b1);   // discharge, stray start (R11)
    run_conv(10'b0000000000, 2, 1, 1'b0);   // discharge clamps to 0 (R9)
    run_conv(10'b1111111111, 99, 3, 1'b0);  // no flip, saturate (R8)
    run_conv(10'b1000000000, 15, 1, 1'b0);  // flip on the 15th step
    run_conv(10'b0000000001, 1, 2, 1'b1);   // charge, flip on first step

    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R10 all results seen", exp_q.size(), 0);
    summary();
    $finish;
  end
endmodule